// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between a simple host write request and one port of an asynchronous 16-bit static RAM that also exposes a separate semaphore space. The host offers an address, a data word, a two-bit byte mask, a target flag (array or semaphore) and a framing flag. Once accepted, the sequencer plays out address setup, a write window, data hold and write recovery on the memory pins. All delays are parameters counted in clock cycles.

Two framings exist. When the write is framed by R/W, the enables fall first and R/W opens and closes the window. When it is framed by the enables, R/W falls first and the chip/semaphore enable and byte enables open and close the window. The output-enable pin is tied to a level chosen by a parameter. When that level is active and the write is framed by R/W, the data driver waits for the memory's outputs to release before it turns on.

Top module: `sram_wr_seq`

## Requirements
- R1: A write window is any cycle with R/W low, chip or semaphore enable low and at least one byte enable low. Each accepted request yields exactly one contiguous window carrying the latched address, data and mask. Upper byte enable low means mask bit 1 and lower byte enable low means mask bit 0.
- R2: The address pins never change between two consecutive cycles that both have R/W, an enable and a byte enable all low.
- R3: With R/W framing, the window lasts max(T_WP, D + T_DW, T_AW - T_AS, T_EW - T_AS) cycles. D is T_WZ when OE_LOW is 1 and 0 otherwise.
- R4: An array write (target flag 0) drives chip enable low and keeps semaphore enable high. A semaphore write (target flag 1) does the reverse. The two enables are never low together.
- R5: From the accepting edge, ready stays low for T_AS + window + max(T_DH, T_WR, 2) cycles and then returns high.
- R6: With R/W framing (flag 0), R/W falls in the cycle the window opens while the enables were already low. With enable framing (flag 1), R/W was already low and the enables fall as the window opens.
- R7: Data is driven for at least T_DW cycles up to the end of the window, stays driven and unchanged for T_DH cycles after it, and is stable while driven.
- R8: With R/W framing and OE_LOW = 1, the data driver is off in the first window cycle and turns on T_WZ cycles in. In every other case it is on from the first window cycle.
- R9: A request raised and dropped while ready is low is not accepted and produces no window.
- R10: A request with mask 2'b00 is not accepted: ready stays high and no window appears.
- R11: Any timing parameter below 1 is treated as 1.
- R12: Output enable sits at its parameter level (low when OE_LOW = 1) for the whole write.
- R13: With enable framing, the window lasts max(T_EW, T_DW, T_AW - T_AS) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Host write request |
| ready | output | 1 | Sequencer idle, request may be accepted |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| wr_be | input | 2 | Byte mask, bit 1 upper, bit 0 lower |
| wr_sem | input | 1 | 1 targets semaphore space |
| wr_enctl | input | 1 | 1 frames the write with the enables, 0 with R/W |
| mem_addr | output | AW | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_sem_n | output | 1 | Semaphore enable, active low |
| mem_rw_n | output | 1 | R/W, low writes |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DW | Data to the bus |
| mem_dq_oe | output | 1 | Tri-state driver enable for mem_dq_out |

## Verification
The scoreboard measures each window on the pins and compares its length separately for each framing. An OE-blind sequencer would give the R/W-framed pulse the short length or turn the driver on too early, into the memory's still-active outputs. It records which strobe fell last, so a swapped framing order shows up even when the lengths agree, and it checks the chip and semaphore enables per target. Intrusive requests during a busy cycle and a zero mask must leave no window in the queue. A second instance with zero timings checks that the clamp gives the expected minimum busy length.

// File: rtl/sram_wr_seq.sv
module sram_wr_seq #(
  parameter int AW     = 14,
  parameter int DW     = 16,
  parameter int T_AS   = 2,
  parameter int T_WP   = 3,
  parameter int T_WZ   = 2,
  parameter int T_DW   = 2,
  parameter int T_DH   = 1,
  parameter int T_WR   = 2,
  parameter int T_EW   = 3,
  parameter int T_AW   = 5,
  parameter bit OE_LOW = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  output logic          ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    wr_be,
  input  logic          wr_sem,
  input  logic          wr_enctl,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_sem_n,
  output logic          mem_rw_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe
);

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int C_AS = mx(T_AS, 1);
  localparam int C_WP = mx(T_WP, 1);
  localparam int C_WZ = mx(T_WZ, 1);
  localparam int C_DW = mx(T_DW, 1);
  localparam int C_DH = mx(T_DH, 1);
  localparam int C_WR = mx(T_WR, 1);
  localparam int C_EW = mx(T_EW, 1);
  localparam int C_AW = mx(T_AW, 1);

  localparam int D_RW = OE_LOW ? C_WZ : 0;
  localparam int P_RW = mx(mx(C_WP, D_RW + C_DW), mx(C_AW - C_AS, C_EW - C_AS));
  localparam int P_EN = mx(mx(C_EW, C_DW), C_AW - C_AS);
  localparam int P_TL = mx(mx(C_DH, C_WR), 2);
  localparam int CW   = $clog2(mx(mx(P_RW, P_EN), mx(P_TL, C_AS)) + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_PULSE, S_TAIL} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_r;
  logic [DW-1:0] d_r;
  logic [1:0]    be_r;
  logic          sem_r;
  logic          enm_r;

  logic [CW-1:0] plen, dstart;
  assign plen   = enm_r ? CW'(P_EN) : CW'(P_RW);
  assign dstart = enm_r ? '0 : CW'(D_RW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      a_r   <= '0;
      d_r   <= '0;
      be_r  <= '0;
      sem_r <= 1'b0;
      enm_r <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req && wr_be != 2'b00) begin
          a_r   <= wr_addr;
          d_r   <= wr_data;
          be_r  <= wr_be;
          sem_r <= wr_sem;
          enm_r <= wr_enctl;
          cnt   <= '0;
          st    <= S_SETUP;
        end
        S_SETUP: if (cnt == CW'(C_AS - 1)) begin
          cnt <= '0;
          st  <= S_PULSE;
        end else cnt <= cnt + 1'b1;
        S_PULSE: if (cnt == plen - 1'b1) begin
          cnt <= '0;
          st  <= S_TAIL;
        end else cnt <= cnt + 1'b1;
        default: if (cnt == CW'(P_TL - 1)) begin
          cnt <= '0;
          st  <= S_IDLE;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  logic pre_en, pre_rw, ce_on, be_on, rw_on, tail0;
  assign tail0  = (st == S_TAIL) && (cnt == '0);
  assign pre_en = (st == S_SETUP) && !enm_r;
  assign pre_rw = (st == S_SETUP) && enm_r;
  assign ce_on  = pre_en || (st == S_PULSE) || (tail0 && !enm_r);
  assign be_on  = pre_en || (st == S_PULSE);
  assign rw_on  = pre_rw || (st == S_PULSE) || (tail0 && enm_r);

  assign ready      = (st == S_IDLE);
  assign mem_addr   = a_r;
  assign mem_ce_n   = !(ce_on && !sem_r);
  assign mem_sem_n  = !(ce_on && sem_r);
  assign mem_ub_n   = !(be_on && be_r[1]);
  assign mem_lb_n   = !(be_on && be_r[0]);
  assign mem_rw_n   = !rw_on;
  assign mem_oe_n   = !OE_LOW;
  assign mem_dq_out = d_r;
  assign mem_dq_oe  = ((st == S_PULSE) && (cnt >= dstart)) ||
                      ((st == S_TAIL) && (cnt < CW'(C_DH)));

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
  parameter int AW = 14,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          ready,
  input logic [1:0]    wr_be,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_sem_n,
  input logic          mem_rw_n,
  input logic          mem_ub_n,
  input logic          mem_lb_n,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe
);
  logic win;
  assign win = !mem_rw_n && !(mem_ce_n && mem_sem_n) && !(mem_ub_n && mem_lb_n);

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    win |=> $stable(mem_addr)); // R2
  AST_CE_SEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_ce_n && !mem_sem_n)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_rw_n && mem_ce_n && mem_sem_n && !mem_dq_oe)); // R5
  AST_DQ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R7
  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req && wr_be == 2'b00) |=> ready); // R10
endmodule

bind sram_wr_seq sram_wr_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .wr_be(wr_be),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_sem_n(mem_sem_n),
  .mem_rw_n(mem_rw_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
  .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe));

// File: tb/sram_wr_seq_test.sv
`timescale 1ns/1ps
module sram_wr_seq_test;
  localparam int AW = 14, DW = 16;
  localparam int T_AS = 2, T_WP = 3, T_WZ = 2, T_DW = 2, T_DH = 1, T_WR = 2, T_EW = 3, T_AW = 5;
  localparam bit OE_LOW = 1'b1;

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  localparam int E_RW = mx(mx(T_WP, (OE_LOW ? T_WZ : 0) + T_DW), mx(T_AW - T_AS, T_EW - T_AS));
  localparam int E_EN = mx(mx(T_EW, T_DW), T_AW - T_AS);
  localparam int E_TL = mx(mx(T_DH, T_WR), 2);

  logic clk = 0, rst_n = 0, req = 0, ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] wr_be = '0;
  logic wr_sem = 0, wr_enctl = 0;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_sem_n, mem_rw_n, mem_ub_n, mem_lb_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out;

  always #2.5 clk = ~clk;

  sram_wr_seq #(.AW(AW), .DW(DW), .T_AS(T_AS), .T_WP(T_WP), .T_WZ(T_WZ), .T_DW(T_DW),
    .T_DH(T_DH), .T_WR(T_WR), .T_EW(T_EW), .T_AW(T_AW), .OE_LOW(OE_LOW)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .wr_sem(wr_sem), .wr_enctl(wr_enctl), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_sem_n(mem_sem_n), .mem_rw_n(mem_rw_n), .mem_ub_n(mem_ub_n),
    .mem_lb_n(mem_lb_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe));

  logic req_c = 0, rdy_c, enm_c = 0;
  logic [AW-1:0] ca;
  logic [DW-1:0] cd;
  logic cce, csem, crw, cub, clb, coe, cdqoe;
  sram_wr_seq #(.AW(AW), .DW(DW), .T_AS(0), .T_WP(0), .T_WZ(0), .T_DW(0),
    .T_DH(0), .T_WR(0), .T_EW(0), .T_AW(0), .OE_LOW(1'b1)) uut_c (
    .clk(clk), .rst_n(rst_n), .req(req_c), .ready(rdy_c), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(2'b11), .wr_sem(1'b0), .wr_enctl(enm_c), .mem_addr(ca), .mem_ce_n(cce),
    .mem_sem_n(csem), .mem_rw_n(crw), .mem_ub_n(cub), .mem_lb_n(clb), .mem_oe_n(coe),
    .mem_dq_out(cd), .mem_dq_oe(cdqoe));

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [1:0] be;
    logic sem;
    logic enm;
  } item_t;
  item_t exp_q[$];

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic pwin = 0, prw = 1, open_rw_fell = 0, open_dq = 0, open_ce = 1, open_oe = 1;
  logic [AW-1:0] open_a;
  logic [DW-1:0] last_d;
  logic [1:0] open_be;
  int wlen = 0, drv = 0, n_win = 0;

  always @(negedge clk) begin
    logic win;
    item_t it;
    win = !mem_rw_n && !(mem_ce_n && mem_sem_n) && !(mem_ub_n && mem_lb_n);
    if (rst_n) begin
      if (win && !pwin) begin
        open_rw_fell = prw;
        open_dq = mem_dq_oe;
        open_ce = mem_ce_n;
        open_oe = mem_oe_n;
        open_a = mem_addr;
        open_be = {!mem_ub_n, !mem_lb_n};
        wlen = 1;
        drv = mem_dq_oe ? 1 : 0;
        last_d = mem_dq_out;
      end else if (win) begin
        wlen++;
        drv = mem_dq_oe ? drv + 1 : 0;
        last_d = mem_dq_out;
      end else if (pwin) begin
        n_win++;
        if (exp_q.size() == 0) check(0, "R9 unexpected window", n_win, 0);
        else begin
          it = exp_q.pop_front();
          check(open_a == it.a && mem_addr == it.a, "R1/R2 address", open_a, it.a);
          check(last_d == it.d, "R1 data", last_d, it.d);
          check(open_be == it.be, "R1 mask", open_be, it.be);
          check(open_ce == it.sem, "R4 target enable", open_ce, it.sem);
          check(wlen == (it.enm ? E_EN : E_RW), it.enm ? "R13 window length" : "R3 window length",
                wlen, it.enm ? E_EN : E_RW);
          check(open_rw_fell == !it.enm, "R6 framing order", open_rw_fell, !it.enm);
          check(open_dq == (it.enm || !OE_LOW), "R8 driver at open", open_dq, it.enm || !OE_LOW);
          check(drv >= T_DW, "R7 data setup", drv, T_DW);
          check(mem_dq_oe && mem_dq_out == it.d, "R7 data hold", mem_dq_oe, 1);
          check(open_oe == !OE_LOW, "R12 output enable", open_oe, !OE_LOW);
        end
      end
      pwin <= win;
      prw <= mem_rw_n;
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be,
                    input logic sem, input logic enm, input bit intrude);
    int n;
    item_t it;
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_be = be; wr_sem = sem; wr_enctl = enm; req = 1;
    if (be != 2'b00) begin
      it.a = a; it.d = d; it.be = be; it.sem = sem; it.enm = enm;
      exp_q.push_back(it);
    end
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (i == 0) req = 0;
      if (intrude && n == 2) begin req = 1; wr_data = ~d; wr_addr = ~a; end
      if (intrude && n == 3) req = 0;
      if (ready) break;
      n++;
    end
    req = 0;
    if (be == 2'b00) check(n == 0, "R10 zero mask ready", n, 0);
    else check(n == T_AS + (enm ? E_EN : E_RW) + E_TL, "R5 busy length", n,
               T_AS + (enm ? E_EN : E_RW) + E_TL);
  endtask

  task automatic clamp_run(input logic enm, input int expn);
    int n;
    @(negedge clk);
    enm_c = enm; req_c = 1;
    n = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      req_c = 0;
      if (rdy_c) break;
      n++;
    end
    check(n == expn, "R11 clamped busy length", n, expn);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    check(ready && mem_rw_n && mem_ce_n && mem_sem_n && mem_ub_n && mem_lb_n && !mem_dq_oe,
          "R5 reset state", {ready, mem_rw_n, mem_ce_n, mem_dq_oe}, 4'b1110);
    rst_n = 1;
    repeat (2) @(negedge clk);
    wr(14'h0123, 16'hA5A5, 2'b11, 0, 0, 0);
    wr(14'h3FFF, 16'h5A5A, 2'b11, 0, 1, 0);
    wr(14'h0001, 16'h00FF, 2'b01, 0, 0, 0);
    wr(14'h2000, 16'hFF00, 2'b10, 0, 1, 0);
    wr(14'h0005, 16'h0001, 2'b11, 1, 0, 0);
    wr(14'h0006, 16'h0000, 2'b01, 1, 1, 0);
    w0 = n_win;
    wr(14'h1111, 16'h1234, 2'b00, 0, 0, 0);
    repeat (8) @(negedge clk);
    check(n_win == w0, "R10 no window on zero mask", n_win, w0);
    wr(14'h0AAA, 16'hBEEF, 2'b11, 0, 0, 1);
    wr(14'h0555, 16'hCAFE, 2'b11, 1, 1, 1);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0 && n_win == 8, "R9 one window per accepted request", n_win, 8);
    clamp_run(0, 5);
    clamp_run(1, 4);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule